// File: doc/BRIEF.md
# Shift, Rotate and Mask Unit with Multiply-Quotient Register Merge

This block is the rotate, shift and mask datapath for the legacy shift family that works through a 32-bit multiply-quotient (MQ) register. A decoder picks an operation and supplies the operand words and the instruction fields. The unit returns the result word, the next MQ value, a write-enable for MQ and the carry bit. The MQ register and the general registers are held outside the block, and so is the writeback.

Inside the block, one left rotator and one mask generator serve every operation. The mask generator wraps when the start position lies after the end position. The shift-with-MQ operations place each rotated value in MQ. Later merge and long-shift operations blend MQ back in under the mask. The logic is combinational, and a single register stage (synchronous, active-high reset) holds the outputs. Results therefore appear one clock after the inputs are presented.

Top module: `pmq_shift_unit`

## Requirements
- R1: While `rst` is high, the registered outputs reset to `result`=0, `mq_next`=0, `ca`=0 and `mq_we`=0. Otherwise each output reflects the inputs sampled at the previous rising edge.
- R2: Mask definitions. Bit positions are counted from the MSB, so position p is bit 31-p. mask(mb,me) sets positions mb..me when mb<=me, and sets positions mb..31 together with 0..me when mb>me. rot(x,n) is x rotated left by n. The amount n is `imm_sh` when `imm_sel`=1 and `src_b[4:0]` otherwise, for op codes 0, 1, 2, 3 and 6.
- R3: op 0 gives `result` = `src_s` shifted left by n, `mq_next` = rot(`src_s`,n) and `mq_we`=1.
- R4: op 1 gives `result` = `src_s` shifted right logically by n, `mq_next` = rot(`src_s`,n) and `mq_we`=1.
- R5: op 2 gives `result` = (rot & mask(0,31-n)) | (`mq_in` & ~mask(0,31-n)), `mq_next` = rot and `mq_we`=1.
- R6: op 3 gives the same merge as op 2 but with mask(n,31), plus `mq_next` = rot and `mq_we`=1.
- R7: ops 4 and 5 always take n from `src_b[4:0]` and use mask(0,31-n) for op 4 or mask(n,31) for op 5. When `src_b[31:5]` is nonzero, `result` = `mq_in` & mask. Otherwise `result` is the op 2 or op 3 merge. `mq_we`=0.
- R8: op 6 gives `result` = `src_s` shifted right arithmetically by n, `mq_next` = rot and `mq_we`=1. `ca`=1 exactly when `src_s[31]`=1 and some bit shifted out is one.
- R9: `ca` is 0 for every op other than 6.
- R10: op 7 rotates `src_s` by `src_b[4:0]` and inserts it into `src_a` under mask(`fld_mb`,`fld_me`), including the wrapped case. `mq_we`=0.
- R11: op 8 takes start=`src_s[4:0]` and end=`src_b[4:0]`. If start=end+1, the result is all ones. If start>end+1, the result is ~mask(end+1,start-1). Otherwise it is mask(start,end). `mq_we`=0.
- R12: op 9 gives `result` = (`src_s` & `src_b`) | (`src_a` & ~`src_b`) with `mq_we`=0.
- R13: Whenever `mq_we`=0, `mq_next` equals `mq_in`. Op codes 10 to 15 give `result`=0, `ca`=0 and `mq_we`=0.
- R14: An amount of 0 leaves `mq_next` = `src_s` for the MQ-writing ops, with no out-of-range shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code (0..9) |
| imm_sel | input | 1 | Take the amount from `imm_sh` for ops 0-3 and 6 |
| imm_sh | input | 5 | Immediate shift amount field |
| fld_mb | input | 5 | Mask begin field for op 7 |
| fld_me | input | 5 | Mask end field for op 7 |
| src_s | input | 32 | Source operand |
| src_a | input | 32 | Target operand, merged into by ops 7 and 9 |
| src_b | input | 32 | Amount or mask operand |
| mq_in | input | 32 | Current MQ value |
| result | output | 32 | Result word |
| mq_next | output | 32 | Next MQ value |
| ca | output | 1 | Carry from the arithmetic shift |
| mq_we | output | 1 | MQ write enable |

## Verification
Every result, along with `mq_next`, `ca` and `mq_we`, is due exactly one rising edge after its inputs are applied, because only the output register lies between the inputs and the ports. The bench changes inputs on a falling edge and waits one full cycle. It then samples on the next falling edge, which is half a period after the capturing edge. The expected words are built from a position-by-position mask model and a concatenation rotate, and neither shares structure with the barrel and shift logic of the design.

// File: rtl/pmq_pkg.sv
package pmq_pkg;

    parameter int unsigned DATA_W = 32;
    parameter int unsigned AMT_W  = $clog2(DATA_W);

    typedef enum logic [3:0] {
        OP_SHL_EXT  = 4'd0,
        OP_SHR_EXT  = 4'd1,
        OP_SHL_MRG  = 4'd2,
        OP_SHR_MRG  = 4'd3,
        OP_SHL_LONG = 4'd4,
        OP_SHR_LONG = 4'd5,
        OP_SHR_ARI  = 4'd6,
        OP_ROT_INS  = 4'd7,
        OP_MASK_GEN = 4'd8,
        OP_MASK_INS = 4'd9
    } pmq_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic [DATA_W-1:0] mq_next;
        logic              ca;
        logic              mq_we;
    } pmq_out_t;

    function automatic logic op_writes_mq(input pmq_op_e op);
        return (op == OP_SHL_EXT) || (op == OP_SHR_EXT) || (op == OP_SHL_MRG) ||
               (op == OP_SHR_MRG) || (op == OP_SHR_ARI);
    endfunction

    function automatic logic op_amount_from_b(input pmq_op_e op);
        return (op == OP_SHL_LONG) || (op == OP_SHR_LONG) || (op == OP_ROT_INS);
    endfunction

endpackage

// File: rtl/pmq_rotator.sv
module pmq_rotator #(
    parameter int unsigned W   = pmq_pkg::DATA_W,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] amt,
    output logic [W-1:0]   dout
);
    logic [W-1:0] stg [SHW+1];

    assign stg[0] = din;

    for (genvar i = 0; i < SHW; i++) begin : g_stage
        localparam int unsigned K = 1 << i;
        assign stg[i+1] = amt[i] ? {stg[i][W-1-K:0], stg[i][W-1:W-K]} : stg[i];
    end

    assign dout = stg[SHW];
endmodule

// File: rtl/pmq_mask_gen.sv
module pmq_mask_gen #(
    parameter int unsigned W   = pmq_pkg::DATA_W,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [SHW-1:0] mb,
    input  logic [SHW-1:0] me,
    output logic [W-1:0]   mask
);
    localparam logic [W-1:0]   ONES = '1;
    localparam logic [SHW-1:0] TOP  = SHW'(W - 1);

    logic [W-1:0]   from_mb;
    logic [W-1:0]   to_me;
    logic [SHW-1:0] lsh;

    always_comb begin
        lsh     = TOP - me;
        from_mb = ONES >> mb;
        to_me   = ONES << lsh;
        mask    = (mb <= me) ? (from_mb & to_me) : (from_mb | to_me);
    end
endmodule

// File: rtl/pmq_carry_detect.sv
module pmq_carry_detect #(
    parameter int unsigned W   = pmq_pkg::DATA_W,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic [W-1:0]   src,
    input  logic [SHW-1:0] amt,
    output logic           carry
);
    localparam logic [W-1:0] ONES = '1;

    logic [W-1:0] lost_bits;

    always_comb begin
        lost_bits = src & ~(ONES << amt);
        carry     = src[W-1] & (|lost_bits);
    end
endmodule

// File: rtl/pmq_shift_unit.sv
module pmq_shift_unit
    import pmq_pkg::*;
#(
    parameter int unsigned W   = DATA_W,
    parameter int unsigned SHW = $clog2(W)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     op_sel,
    input  logic           imm_sel,
    input  logic [SHW-1:0] imm_sh,
    input  logic [SHW-1:0] fld_mb,
    input  logic [SHW-1:0] fld_me,
    input  logic [W-1:0]   src_s,
    input  logic [W-1:0]   src_a,
    input  logic [W-1:0]   src_b,
    input  logic [W-1:0]   mq_in,
    output logic [W-1:0]   result,
    output logic [W-1:0]   mq_next,
    output logic           ca,
    output logic           mq_we
);
    localparam logic [SHW-1:0] TOP = SHW'(W - 1);

    pmq_op_e        op;
    logic [SHW-1:0] amt;
    logic [SHW-1:0] mk_mb;
    logic [SHW-1:0] mk_me;
    logic [W-1:0]   rot;
    logic [W-1:0]   mask;
    logic           sra_carry;
    logic           long_amt;
    logic           gen_full;
    logic           gen_plain;
    logic [SHW-1:0] g_start;
    logic [SHW-1:0] g_end;
    logic [W-1:0]   merged;
    pmq_out_t       nxt;
    pmq_out_t       q;

    // amount and mask-field selection
    always_comb begin
        op        = pmq_op_e'(op_sel);
        amt       = (imm_sel && !op_amount_from_b(op)) ? imm_sh : src_b[SHW-1:0];
        long_amt  = |src_b[W-1:SHW];
        g_start   = src_s[SHW-1:0];
        g_end     = src_b[SHW-1:0];
        gen_full  = ({1'b0, g_end} + 1'b1) == {1'b0, g_start};
        gen_plain = g_start <= g_end;
        unique case (op)
            OP_SHL_MRG, OP_SHL_LONG: begin
                mk_mb = '0;
                mk_me = TOP - amt;
            end
            OP_SHR_MRG, OP_SHR_LONG: begin
                mk_mb = amt;
                mk_me = TOP;
            end
            OP_ROT_INS: begin
                mk_mb = fld_mb;
                mk_me = fld_me;
            end
            OP_MASK_GEN: begin
                mk_mb = gen_plain ? g_start : g_end + 1'b1;
                mk_me = gen_plain ? g_end   : g_start - 1'b1;
            end
            default: begin
                mk_mb = '0;
                mk_me = TOP;
            end
        endcase
    end

    pmq_rotator #(.W(W), .SHW(SHW)) u_rot (
        .din  (src_s),
        .amt  (amt),
        .dout (rot)
    );

    pmq_mask_gen #(.W(W), .SHW(SHW)) u_mask (
        .mb   (mk_mb),
        .me   (mk_me),
        .mask (mask)
    );

    pmq_carry_detect #(.W(W), .SHW(SHW)) u_carry (
        .src   (src_s),
        .amt   (amt),
        .carry (sra_carry)
    );

    // result selection
    always_comb begin
        merged      = (rot & mask) | (mq_in & ~mask);
        nxt.result  = '0;
        nxt.mq_next = op_writes_mq(op) ? rot : mq_in;
        nxt.mq_we   = op_writes_mq(op);
        nxt.ca      = 1'b0;
        unique case (op)
            OP_SHL_EXT:  nxt.result = src_s << amt;
            OP_SHR_EXT:  nxt.result = src_s >> amt;
            OP_SHL_MRG,
            OP_SHR_MRG:  nxt.result = merged;
            OP_SHL_LONG,
            OP_SHR_LONG: nxt.result = long_amt ? (mq_in & mask) : merged;
            OP_SHR_ARI: begin
                nxt.result = W'($signed(src_s) >>> amt);
                nxt.ca     = sra_carry;
            end
            OP_ROT_INS:  nxt.result = (rot & mask) | (src_a & ~mask);
            OP_MASK_GEN: nxt.result = gen_full ? '1 : (gen_plain ? mask : ~mask);
            OP_MASK_INS: nxt.result = (src_s & src_b) | (src_a & ~src_b);
            default:     nxt.result = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= nxt;
        end
    end

    assign result  = q.result;
    assign mq_next = q.mq_next;
    assign ca      = q.ca;
    assign mq_we   = q.mq_we;
endmodule

// File: rtl/pmq_shift_unit_chk.sv
module pmq_shift_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_sel,
    input logic        imm_sel,
    input logic [31:0] src_s,
    input logic [31:0] src_b,
    input logic [31:0] mq_in,
    input logic [31:0] result,
    input logic [31:0] mq_next,
    input logic        ca,
    input logic        mq_we
);
    AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) && !rst
        |-> (result == 32'd0) && !mq_we && !ca);  // R1

    AST_CA_ONLY_ARI: assert property (@(posedge clk) disable iff (rst)
        ($past(op_sel) != 4'd6) |-> !ca);  // R9

    AST_CA_NONNEG: assert property (@(posedge clk) disable iff (rst)
        ($past(op_sel) == 4'd6 && !$past(src_s[31])) |-> !ca);  // R8

    AST_NO_WE_INSERT: assert property (@(posedge clk) disable iff (rst)
        ($past(op_sel) >= 4'd7 || $past(op_sel) == 4'd4 || $past(op_sel) == 4'd5)
        |-> !mq_we && (mq_next == $past(mq_in)));  // R13

    AST_MASKGEN_FULL: assert property (@(posedge clk) disable iff (rst)
        ($past(op_sel) == 4'd8 &&
         ({1'b0, $past(src_b[4:0])} + 6'd1) == {1'b0, $past(src_s[4:0])})
        |-> (result == 32'hFFFF_FFFF));  // R11

    AST_MASKINS_ALLB: assert property (@(posedge clk) disable iff (rst)
        ($past(op_sel) == 4'd9 && $past(src_b) == 32'hFFFF_FFFF)
        |-> (result == $past(src_s)));  // R12

    AST_ROT_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(op_sel) <= 4'd3 && !$past(imm_sel) && $past(src_b[4:0]) == 5'd0)
        |-> (mq_next == $past(src_s)) && mq_we);  // R14
endmodule

bind pmq_shift_unit pmq_shift_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_sel  (op_sel),
    .imm_sel (imm_sel),
    .src_s   (src_s),
    .src_b   (src_b),
    .mq_in   (mq_in),
    .result  (result),
    .mq_next (mq_next),
    .ca      (ca),
    .mq_we   (mq_we)
);

// File: tb/pmq_shift_unit_bench.sv
`timescale 1ns/1ps
module pmq_shift_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_sel = '0;
    logic        imm_sel = 1'b0;
    logic [4:0]  imm_sh = '0;
    logic [4:0]  fld_mb = '0;
    logic [4:0]  fld_me = '0;
    logic [31:0] src_s = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [31:0] mq_in = '0;
    logic [31:0] result;
    logic [31:0] mq_next;
    logic        ca;
    logic        mq_we;

    int n_checks = 0;
    int n_err    = 0;

    always #2 clk = ~clk;

    pmq_shift_unit u_pmq_shift_unit (
        .clk(clk), .rst(rst), .op_sel(op_sel), .imm_sel(imm_sel), .imm_sh(imm_sh),
        .fld_mb(fld_mb), .fld_me(fld_me), .src_s(src_s), .src_a(src_a),
        .src_b(src_b), .mq_in(mq_in), .result(result), .mq_next(mq_next),
        .ca(ca), .mq_we(mq_we)
    );

    function automatic logic [31:0] ref_mask(input int mb, input int me);
        logic [31:0] m = '0;
        for (int p = 0; p < 32; p++) begin
            if (mb <= me) m[31-p] = (p >= mb) && (p <= me);
            else          m[31-p] = (p >= mb) || (p <= me);
        end
        return m;
    endfunction

    function automatic logic [31:0] ref_rot(input logic [31:0] x, input int n);
        logic [63:0] d = {x, x};
        return d[63-n -: 32];
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run(input int op, input logic imm, input int ish, input int mb,
                       input int me, input logic [31:0] s, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] mq);
        @(negedge clk);
        op_sel = 4'(op); imm_sel = imm; imm_sh = 5'(ish); fld_mb = 5'(mb);
        fld_me = 5'(me); src_s = s; src_a = a; src_b = b; mq_in = mq;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        run(6, 1'b0, 0, 0, 0, 32'hFFFF_FFFF, 32'h1, 32'h3, 32'h5);
        chk("R1 result", result, 32'h0);
        chk("R1 mq_next", mq_next, 32'h0);
        chk("R1 flags", {30'd0, ca, mq_we}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_ext;
        logic [31:0] s = 32'h8123_4567;
        run(0, 1'b0, 0, 0, 0, s, 0, 32'd12, 32'h0);
        chk("R3 result", result, s << 12);
        chk("R3 mq", mq_next, ref_rot(s, 12));
        chk("R3 we", {31'd0, mq_we}, 32'd1);
        run(1, 1'b0, 0, 0, 0, s, 0, 32'd7, 32'h0);
        chk("R4 result", result, s >> 7);
        chk("R4 mq", mq_next, ref_rot(s, 7));
    endtask

    task automatic t_imm;
        logic [31:0] s = 32'hDEAD_BEEF;
        run(0, 1'b1, 9, 0, 0, s, 0, 32'd3, 32'h0);
        chk("R2 imm amount", result, s << 9);
        chk("R2 imm rot", mq_next, ref_rot(s, 9));
    endtask

    task automatic t_merge;
        logic [31:0] s  = 32'h1234_5678;
        logic [31:0] mq = 32'hA5A5_A5A5;
        logic [31:0] m;
        m = ref_mask(0, 31 - 8);
        run(2, 1'b0, 0, 0, 0, s, 0, 32'd8, mq);
        chk("R5 merge", result, (ref_rot(s, 8) & m) | (mq & ~m));
        chk("R5 mq", mq_next, ref_rot(s, 8));
        m = ref_mask(20, 31);
        run(3, 1'b1, 20, 0, 0, s, 0, 32'd1, mq);
        chk("R6 merge", result, (ref_rot(s, 20) & m) | (mq & ~m));
        chk("R6 we", {31'd0, mq_we}, 32'd1);
    endtask

    task automatic t_long;
        logic [31:0] s  = 32'hCAFE_F00D;
        logic [31:0] mq = 32'h0F0F_3C3C;
        logic [31:0] m;
        m = ref_mask(0, 31 - 4);
        run(4, 1'b1, 17, 0, 0, s, 0, 32'd36, mq);
        chk("R7 long left big", result, mq & m);
        chk("R7 long mq hold", mq_next, mq);
        chk("R7 long we", {31'd0, mq_we}, 32'd0);
        m = ref_mask(4, 31);
        run(5, 1'b0, 0, 0, 0, s, 0, 32'd4, mq);
        chk("R7 long right merge", result, (ref_rot(s, 4) & m) | (mq & ~m));
        m = ref_mask(3, 31);
        run(5, 1'b0, 0, 0, 0, s, 0, 32'h8000_0003, mq);
        chk("R7 long right big", result, mq & m);
    endtask

    task automatic t_sra;
        run(6, 1'b0, 0, 0, 0, 32'h8000_0010, 0, 32'd4, 0);
        chk("R8 sra result", result, 32'hF800_0001);
        chk("R8 ca zero lost", {31'd0, ca}, 32'd0);
        run(6, 1'b0, 0, 0, 0, 32'h8000_0010, 0, 32'd5, 0);
        chk("R8 ca set", {31'd0, ca}, 32'd1);
        chk("R8 mq", mq_next, ref_rot(32'h8000_0010, 5));
        run(6, 1'b1, 4, 0, 0, 32'h0000_00FF, 0, 32'd0, 0);
        chk("R8 ca positive", {31'd0, ca}, 32'd0);
        chk("R8 positive result", result, 32'h0000_000F);
        run(0, 1'b0, 0, 0, 0, 32'hFFFF_FFFF, 0, 32'd5, 0);
        chk("R9 ca other op", {31'd0, ca}, 32'd0);
    endtask

    task automatic t_rotins;
        logic [31:0] s = 32'h1357_9BDF;
        logic [31:0] a = 32'h5555_AAAA;
        logic [31:0] m;
        m = ref_mask(4, 11);
        run(7, 1'b1, 30, 4, 11, s, a, 32'd13, 32'h77);
        chk("R10 insert", result, (ref_rot(s, 13) & m) | (a & ~m));
        chk("R10 we", {31'd0, mq_we}, 32'd0);
        m = ref_mask(28, 3);
        run(7, 1'b0, 0, 28, 3, s, a, 32'd6, 32'h77);
        chk("R10 wrapped", result, (ref_rot(s, 6) & m) | (a & ~m));
    endtask

    task automatic t_maskgen;
        run(8, 1'b0, 0, 0, 0, 32'd3, 0, 32'd7, 0);
        chk("R11 plain", result, ref_mask(3, 7));
        run(8, 1'b0, 0, 0, 0, 32'd8, 0, 32'd7, 0);
        chk("R11 full", result, 32'hFFFF_FFFF);
        run(8, 1'b0, 0, 0, 0, 32'd20, 0, 32'd5, 0);
        chk("R11 inverted", result, ~ref_mask(6, 19));
        run(8, 1'b0, 0, 0, 0, 32'd0, 0, 32'd31, 0);
        chk("R11 whole", result, 32'hFFFF_FFFF);
    endtask

    task automatic t_maskins;
        run(9, 1'b0, 0, 0, 0, 32'hF0F0_1234, 32'h0F0F_ABCD, 32'hFF00_FF00, 32'h9);
        chk("R12 insert", result, 32'hF00F_12CD);
        chk("R12 we", {31'd0, mq_we}, 32'd0);
        chk("R13 mq hold", mq_next, 32'h9);
    endtask

    task automatic t_unused;
        run(12, 1'b0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, 32'h44);
        chk("R13 unused result", result, 32'h0);
        chk("R13 unused flags", {30'd0, ca, mq_we}, 32'h0);
        chk("R13 unused mq", mq_next, 32'h44);
    endtask

    task automatic t_rot0;
        run(0, 1'b0, 0, 0, 0, 32'h8765_4321, 0, 32'd32, 0);
        chk("R14 zero result", result, 32'h8765_4321);
        chk("R14 zero mq", mq_next, 32'h8765_4321);
        run(3, 1'b1, 0, 0, 0, 32'h8765_4321, 0, 32'd9, 32'h1111_1111);
        chk("R14 zero merge", result, 32'h8765_4321);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL R1 watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_ext();
        t_imm();
        t_merge();
        t_long();
        t_sra();
        t_rotins();
        t_maskgen();
        t_maskins();
        t_unused();
        t_rot0();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule